// File: doc/BRIEF.md
# Valley-Triggered Switching Cycle Timer

This block produces the gate pulse for a quasi-resonant power converter controller. A supervisor enables it. An external detector reports each resonant valley as a one-cycle pulse. An on-time comparator reports when the programmed on-time has been reached, and a current-limit comparator reports over-current. All durations are counted in cycles of the block clock and are set by parameters. The defaults assume a 10 MHz reference.

Each switching period begins at the rising edge of the gate. During a minimum-period mask, valleys cannot start a new period. After the mask, the first valley starts one. Two fallback timers cover missing valleys. A short one applies when valleys were only seen inside the mask. A long starter applies otherwise. The first pulse after enable always comes from the starter. While the gate is high, the pulse is held for at least a minimum on-time and is cut at a maximum on-time. After a short blanking interval, the current-limit flag ends the pulse in the cycle it appears.

Top module: `qr_cycle_timer`

## Requirements
- R1: Two successive gate rising edges are never closer than MIN_PERIOD cycles. A valley arriving while the period counter is below MIN_PERIOD-1 (counted from 0 in the first gate-high cycle) cannot start a pulse.
- R2: With the gate low and the mask over, a valley in period cycle v starts the next gate pulse in cycle v+1.
- R3: If at least one valley fell inside the mask and none arrived after it, the next pulse starts MIN_PERIOD+FALLBACK_WAIT cycles after the previous rising edge.
- R4: If the fallback does not apply, the next pulse starts STARTER_WAIT cycles after the previous rising edge. After enable rises, the first pulse starts STARTER_WAIT cycles after the first enabled cycle, and valleys before it are ignored.
- R5: The gate is never high for more than TON_MAX consecutive cycles, whether or not the on-time comparator fires.
- R6: When the on-time comparator asserts in gate-high cycle t, the gate falls after max(t, TON_MIN-1)+1 high cycles. It is never shorter than TON_MIN unless the current limit ends it.
- R7: The current-limit flag has no effect in the first LEB_CYC gate-high cycles.
- R8: From gate-high cycle LEB_CYC onward, an asserted current-limit flag drives the gate output low in that same cycle. The pulse then ends.
- R9: After reset, and whenever enable is low, the gate output is low in the same cycle. All timers restart.
- R10: The record of a valley seen in the mask is cleared when each new period starts. A period with no valley then falls back to the starter.
- R11: A valley after the mask that arrives while the gate is still high neither starts a pulse nor arms the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable from the supervisor; low forces the gate off |
| valley_i | input | 1 | One-cycle pulse per detected valley |
| ton_done_i | input | 1 | On-time comparator has reached its threshold |
| ilim_i | input | 1 | Cycle-by-cycle current-limit comparator flag |
| gate_o | output | 1 | Gate-drive pulse |

## Verification
The bench builds the block with MIN_PERIOD=20, FALLBACK_WAIT=6, STARTER_WAIT=60, TON_MAX=30, LEB_CYC=3 and TON_MIN=5. With these values every timer runs out within a few dozen cycles. The starter, the fallback and the maximum on-time can therefore be measured exactly, cycle by cycle, in the same run. Because TON_MAX is larger than MIN_PERIOD, a pulse can still be high when the mask ends, so the case of a valley arriving during a long pulse can be tested. The small LEB_CYC and TON_MIN values put the blanking edge and the minimum-width limit at cycle positions the bench can hit exactly.

// File: rtl/qr_timer_pkg.sv
package qr_timer_pkg;

    // Reason a gate pulse terminates, in priority order of evaluation.
    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_ILIM = 2'd1,
        END_MAX  = 2'd2,
        END_TON  = 2'd3
    } pulse_end_e;

    // Candidate causes for starting a new switching period.
    typedef struct packed {
        logic on_valley;
        logic on_fallback;
        logic on_starter;
    } start_req_t;

    // Bits needed to hold values 0..limit.
    function automatic int cnt_bits(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qr_period_timer.sv
// Period counter, mask-valley record and start-request decoding.
module qr_period_timer
    import qr_timer_pkg::*;
#(
    parameter int MIN_PERIOD    = 85,
    parameter int FALLBACK_WAIT = 50,
    parameter int STARTER_WAIT  = 1300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       gate_q_i,
    input  logic       start_i,
    input  logic       valley_i,
    output start_req_t req_o
);

    localparam int PCW = cnt_bits(max_of(STARTER_WAIT, MIN_PERIOD + FALLBACK_WAIT));
    localparam logic [PCW-1:0] MASK_LAST = PCW'(MIN_PERIOD - 1);
    localparam logic [PCW-1:0] FALLB_AT  = PCW'(MIN_PERIOD + FALLBACK_WAIT - 1);
    localparam logic [PCW-1:0] START_AT  = PCW'(STARTER_WAIT - 1);
    localparam logic [PCW-1:0] CNT_SAT   = {PCW{1'b1}};

    logic [PCW-1:0] per_cnt;
    logic           seen_q;
    logic           primed_q;
    logic           idle;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            per_cnt  <= '0;
            seen_q   <= 1'b0;
            primed_q <= 1'b0;
        end else if (start_i) begin
            per_cnt  <= '0;
            seen_q   <= 1'b0;
            primed_q <= 1'b1;
        end else begin
            if (per_cnt != CNT_SAT) begin
                per_cnt <= per_cnt + PCW'(1);
            end
            if (valley_i && (per_cnt < MASK_LAST)) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign idle = !gate_q_i;

    always_comb begin
        req_o.on_valley   = idle && primed_q && valley_i && (per_cnt >= MASK_LAST);
        req_o.on_fallback = idle && primed_q && seen_q && (per_cnt >= FALLB_AT);
        req_o.on_starter  = idle && (per_cnt >= START_AT);
    end

endmodule

// File: rtl/qr_on_timer.sv
// On-time counter, leading-edge blanking and pulse termination decode.
module qr_on_timer
    import qr_timer_pkg::*;
#(
    parameter int TON_MIN = 13,
    parameter int TON_MAX = 470,
    parameter int LEB_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       gate_q_i,
    input  logic       ton_done_i,
    input  logic       ilim_i,
    output logic       kill_o,
    output pulse_end_e end_o
);

    localparam int OCW = cnt_bits(TON_MAX);
    localparam logic [OCW-1:0] MIN_AT  = OCW'((TON_MIN > 0) ? TON_MIN - 1 : 0);
    localparam logic [OCW-1:0] MAX_AT  = OCW'((TON_MAX > 0) ? TON_MAX - 1 : 0);
    localparam logic [OCW-1:0] CNT_SAT = {OCW{1'b1}};

    logic [OCW-1:0] on_cnt;
    logic           blank_over;

    always_ff @(posedge clk) begin
        if (rst || !en_i || !gate_q_i) begin
            on_cnt <= '0;
        end else if (on_cnt != CNT_SAT) begin
            on_cnt <= on_cnt + OCW'(1);
        end
    end

    generate
        if (LEB_CYC == 0) begin : g_no_blank
            assign blank_over = 1'b1;
        end else begin : g_blank
            localparam logic [OCW-1:0] LEB_C = OCW'(LEB_CYC);
            assign blank_over = (on_cnt >= LEB_C);
        end
    endgenerate

    assign kill_o = gate_q_i && ilim_i && blank_over;

    always_comb begin
        if (!gate_q_i) begin
            end_o = END_NONE;
        end else if (kill_o) begin
            end_o = END_ILIM;
        end else if (on_cnt >= MAX_AT) begin
            end_o = END_MAX;
        end else if (ton_done_i && (on_cnt >= MIN_AT)) begin
            end_o = END_TON;
        end else begin
            end_o = END_NONE;
        end
    end

endmodule

// File: rtl/qr_cycle_timer.sv
// Quasi-resonant switching cycle timer: gate register and start/stop control.
module qr_cycle_timer
    import qr_timer_pkg::*;
#(
    parameter int MIN_PERIOD    = 85,
    parameter int FALLBACK_WAIT = 50,
    parameter int STARTER_WAIT  = 1300,
    parameter int TON_MAX       = 470,
    parameter int LEB_CYC       = 4,
    parameter int TON_MIN       = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic valley_i,
    input  logic ton_done_i,
    input  logic ilim_i,
    output logic gate_o
);

    logic       gate_q;
    logic       start;
    logic       ilim_kill;
    start_req_t req;
    pulse_end_e end_cause;

    qr_period_timer #(
        .MIN_PERIOD   (MIN_PERIOD),
        .FALLBACK_WAIT(FALLBACK_WAIT),
        .STARTER_WAIT (STARTER_WAIT)
    ) period_i (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .gate_q_i(gate_q),
        .start_i (start),
        .valley_i(valley_i),
        .req_o   (req)
    );

    qr_on_timer #(
        .TON_MIN(TON_MIN),
        .TON_MAX(TON_MAX),
        .LEB_CYC(LEB_CYC)
    ) ontime_i (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .gate_q_i  (gate_q),
        .ton_done_i(ton_done_i),
        .ilim_i    (ilim_i),
        .kill_o    (ilim_kill),
        .end_o     (end_cause)
    );

    assign start = en_i && !gate_q && (req.on_valley || req.on_fallback || req.on_starter);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            gate_q <= 1'b0;
        end else if (start) begin
            gate_q <= 1'b1;
        end else if (gate_q && (end_cause != END_NONE)) begin
            gate_q <= 1'b0;
        end
    end

    assign gate_o = en_i && gate_q && !ilim_kill;

endmodule

// File: rtl/qr_cycle_timer_chk.sv
module qr_cycle_timer_chk
    import qr_timer_pkg::*;
#(
    parameter int MIN_PERIOD = 85,
    parameter int TON_MIN    = 13,
    parameter int TON_MAX    = 470,
    parameter int LEB_CYC    = 4
) (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic ilim_i,
    input logic gate_q,
    input logic gate_o
);

    localparam int PW = cnt_bits(MIN_PERIOD);
    localparam int HW = cnt_bits(TON_MAX);
    localparam logic [PW-1:0] PER_LIM = PW'(MIN_PERIOD);
    localparam logic [HW-1:0] HI_SAT  = HW'(TON_MAX);
    localparam logic [HW-1:0] HI_MAX  = HW'(TON_MAX);
    localparam logic [HW-1:0] HI_MIN  = HW'((TON_MIN > 0) ? TON_MIN - 1 : 0);
    localparam logic [HW-1:0] HI_LEB  = HW'(LEB_CYC);

    logic          gate_d;
    logic [PW-1:0] per_cnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_d  <= 1'b0;
            per_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            gate_d <= gate_q;
            if (gate_q && !gate_d) begin
                per_cnt <= PW'(1);
            end else if (per_cnt < PER_LIM) begin
                per_cnt <= per_cnt + PW'(1);
            end
            if (!gate_q) begin
                hi_cnt <= '0;
            end else if (hi_cnt < HI_SAT) begin
                hi_cnt <= hi_cnt + HW'(1);
            end
        end
    end

    p_min_period_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q) |-> (per_cnt >= PER_LIM));

    p_ton_max_r5: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> (hi_cnt < HI_MAX));

    p_ton_min_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_q) && $past(en_i) && !$past(ilim_i)) |-> ($past(hi_cnt) >= HI_MIN));

    p_leb_r7: assert property (@(posedge clk) disable iff (rst)
        (gate_q && en_i && (hi_cnt < HI_LEB)) |-> gate_o);

    p_ilim_kill_r8: assert property (@(posedge clk) disable iff (rst)
        (gate_q && ilim_i && (hi_cnt >= HI_LEB)) |-> !gate_o);

    p_disable_out_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !gate_o);

    p_disable_state_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !gate_q);

endmodule

bind qr_cycle_timer qr_cycle_timer_chk #(
    .MIN_PERIOD(MIN_PERIOD),
    .TON_MIN   (TON_MIN),
    .TON_MAX   (TON_MAX),
    .LEB_CYC   (LEB_CYC)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .en_i  (en_i),
    .ilim_i(ilim_i),
    .gate_q(gate_q),
    .gate_o(gate_o)
);

// File: tb/qr_cycle_timer_tb_top.sv
`timescale 1ns/1ps
module qr_cycle_timer_tb_top;

    localparam int P_MIN   = 20;
    localparam int P_FALLB = 6;
    localparam int P_START = 60;
    localparam int P_TMAX  = 30;
    localparam int P_LEB   = 3;
    localparam int P_TMIN  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic valley = 1'b0;
    logic tdone = 1'b0;
    logic ilim = 1'b0;
    logic gate;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    qr_cycle_timer #(
        .MIN_PERIOD   (P_MIN),
        .FALLBACK_WAIT(P_FALLB),
        .STARTER_WAIT (P_START),
        .TON_MAX      (P_TMAX),
        .LEB_CYC      (P_LEB),
        .TON_MIN      (P_TMIN)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en),
        .valley_i  (valley),
        .ton_done_i(tdone),
        .ilim_i    (ilim),
        .gate_o    (gate)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs mid-cycle and sample the gate in that cycle.
    task automatic step(input logic e, input logic v, input logic t, input logic i, output logic g);
        @(negedge clk);
        en = e; valley = v; tdone = t; ilim = i;
        #1;
        g = gate;
    endtask

    // Current cycle is period cycle 0 with the gate high. Runs until the next rise.
    task automatic run_period(input int vp1, input int vp2, input int tp, input int ip,
                              input int exp_w, input int exp_p, input string tag);
        int  w = -1;
        int  p = -1;
        logic g;
        for (int c = 1; c < 200; c++) begin
            step(1'b1, (c == vp1) || (c == vp2), (w < 0) && (tp >= 0) && (c >= tp), (c == ip), g);
            if (w < 0 && !g) w = c;
            else if (w >= 0 && g) begin p = c; break; end
        end
        check(w == exp_w, {tag, " width"}, w, exp_w);
        check(p == exp_p, {tag, " period"}, p, exp_p);
    endtask

    task automatic t_reset();
        check(gate == 1'b0, "R9 reset", int'(gate), 0);
    endtask

    task automatic t_disabled_hold();
        int highs = 0;
        logic g;
        for (int c = 0; c < 12; c++) begin
            step(1'b0, c[0], 1'b1, c[1], g);
            if (g) highs++;
        end
        check(highs == 0, "R9 gate low while disabled", highs, 0);
    endtask

    // Enable rises in step 0; valleys before the first pulse are ignored (R4).
    task automatic t_first_pulse(input string tag);
        int at = -1;
        logic g;
        for (int c = 0; c < 200; c++) begin
            step(1'b1, (c == 25) || (c == 30), 1'b0, 1'b0, g);
            if (g) begin at = c; break; end
        end
        check(at == P_START, tag, at, P_START);
    endtask

    task automatic t_valley_after_mask();   // R2, R6
        run_period(25, -1, 8, -1, 9, 26, "R2 valley after mask / R6 ton");
    endtask

    task automatic t_valley_at_mask_edge(); // R1, R6 minimum width
        run_period(19, -1, 1, -1, P_TMIN, P_MIN, "R1 mask edge / R6 min on");
    endtask

    task automatic t_fallback();            // R3
        run_period(10, -1, 8, -1, 9, P_MIN + P_FALLB, "R3 fallback");
    endtask

    task automatic t_seen_cleared();        // R10, R4
        run_period(-1, -1, 8, -1, 9, P_START, "R10 seen cleared / R4 starter");
    endtask

    task automatic t_valley_while_high();   // R11, R5
        run_period(19, -1, -1, -1, P_TMAX, P_START, "R11 valley during pulse / R5 max on");
    endtask

    task automatic t_valley_after_long();   // R2, R5
        run_period(35, -1, -1, -1, P_TMAX, 36, "R2 valley after long pulse");
    endtask

    task automatic t_ilim_cut();            // R8
        run_period(22, -1, -1, 6, 6, 23, "R8 current limit");
    endtask

    task automatic t_ilim_blanked();        // R7, R2
        run_period(10, 22, 10, 1, 11, 23, "R7 blanking");
    endtask

    task automatic t_ilim_at_leb();         // R8 boundary
        run_period(19, -1, -1, P_LEB, P_LEB, P_MIN, "R8 first unblanked cycle");
    endtask

    task automatic t_last_mask_valley();    // R3 boundary
        run_period(18, -1, 4, -1, P_TMIN, P_MIN + P_FALLB, "R3 last mask cycle");
    endtask

    task automatic t_disable_mid_pulse();   // R9, R4
        logic g;
        step(1'b1, 1'b0, 1'b0, 1'b0, g);
        check(g == 1'b1, "R9 pulse before disable", int'(g), 1);
        step(1'b0, 1'b0, 1'b0, 1'b0, g);
        check(g == 1'b0, "R9 gate drops with enable", int'(g), 0);
        for (int c = 0; c < 5; c++) step(1'b0, 1'b1, 1'b0, 1'b0, g);
        t_first_pulse("R4 restart after re-enable");
    endtask

    initial begin
        logic g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0, g);
        t_reset();
        t_disabled_hold();
        t_first_pulse("R4 first pulse from starter");
        t_valley_after_mask();
        t_valley_at_mask_edge();
        t_fallback();
        t_seen_cleared();
        t_valley_while_high();
        t_valley_after_long();
        t_ilim_cut();
        t_ilim_blanked();
        t_ilim_at_leb();
        t_last_mask_valley();
        t_disable_mid_pulse();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule